// File: doc/BRIEF.md
# Staged Scratch Buffer with Authorized Page Copy

This block places a 32-byte staging buffer in front of a 512-byte backing memory. A host talks to it over a framed serial bit stream. While `frame` is high, each cycle with `bit_valid` high carries one bit, least significant bit first. The first byte of a frame is a command. The block accepts three commands: fill the buffer, read the buffer back together with its address and status, and commit the buffer to memory.

The backing memory is never written directly. The host first loads the buffer behind a 16-bit target address. It reads the buffer back to verify it. It then issues the commit command and echoes the two address bytes and the status byte exactly. Only when the echo matches does the block copy the written range into memory, one byte per clock.

The status byte records three things: the last offset the host wrote, whether data ran past the end of the buffer, and whether the last byte was left incomplete.

Top module: `scratch_copy_ctrl`

## Requirements
- R1: After synchronous reset, `dout` is 1 and `mem_we` is 0. A read-back returns address bytes 00h and 00h, status byte 00h, and zero buffer data.
- R2: Command 0Fh takes two address bytes, low byte first. Bits 4:0 of the address give the start offset. Each following data bit is stored at the current offset, LSB first, and the offset advances after every 8 bits. Status bits 4:0 hold the offset of the last data bit stored.
- R3: Data bits arriving after the byte at offset 31 is complete are discarded, and status bit 6 (overflow) is set.
- R4: If the frame ends with 1 to 7 bits of a byte written and no overflow occurred, status bit 5 (partial) is set. If overflow occurred, bit 5 stays 0.
- R5: Command AAh returns the low address byte, the high address byte, the status byte, and then buffer bytes from the start offset upward, each LSB first on `dout`. Each bit is presented in the same cycle as the slot that reads it.
- R6: Read slots beyond buffer offset 31 return 1.
- R7: Command 55h takes three bytes. If they equal, in order, the low address byte, the high address byte and the status byte, status bit 7 (accepted) is set. Starting on the cycle after the last echo bit, the block writes buffer offsets start..end to memory, one per cycle. Each write goes to address {target[8:5], offset}.
- R8: If the echo does not match, memory receives no write and the accepted bit keeps its value.
- R9: `dout` is 1 during every copy cycle and 0 after the copy completes, until the frame ends. Dropping `frame` during a copy does not shorten the copy.
- R10: A byte that was only partly written is copied as a whole 8-bit byte: its new bits together with its earlier contents.
- R11: The accepted bit is cleared only by command 0Fh. Reads and copies leave it set.
- R12: Any other command byte is ignored until the frame ends. `dout` stays 1 and no buffer, address, status or memory state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame | input | 1 | High for the duration of one transaction; low returns to command state |
| bit_valid | input | 1 | Marks a cycle that carries one bit slot |
| bit_in | input | 1 | Serial data from host, LSB first |
| dout | output | 1 | Serial data to host; copy progress indicator |
| mem_we | output | 1 | Backing memory write enable |
| mem_addr | output | ADDR_W | Backing memory byte address |
| mem_wdata | output | 8 | Backing memory write data |

## Verification
Read-back bits are combinational from registered state. The bit for a slot is therefore due in the same cycle that slot is presented, before the edge that consumes it. The bench drives each slot just after a falling edge and samples one nanosecond later.

The first memory write is due in the cycle after the edge that takes the final echo bit. Writes continue on consecutive cycles, and the 0 on `dout` follows in the cycle after the last write.

Flag updates caused by the end of a frame are registered on that frame's first low edge. The bench observes them through a later read command. It compares `dout`, `mem_we`, and the write address and data against its own behavioural model in every cycle it drives.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the staged scratch buffer: controller states,
// command codes and status-byte bit positions.
package sp_pkg;
    typedef enum logic [2:0] {
        ST_CMD,
        ST_WADDR,
        ST_WDATA,
        ST_READ,
        ST_AUTH,
        ST_BUSY,
        ST_DONE,
        ST_SINK
    } sp_state_e;

    localparam logic [7:0] OP_WRITE = 8'h0F;
    localparam logic [7:0] OP_READ  = 8'hAA;
    localparam logic [7:0] OP_COPY  = 8'h55;

    localparam int ES_PF = 5;
    localparam int ES_OF = 6;
    localparam int ES_AA = 7;
endpackage

// File: rtl/sp_buffer.sv
`timescale 1ns/1ps
// Staging buffer: 2**OFF_W bytes, written one bit at a time, with two
// independent combinational byte read ports (read-back and copy).
// Assumes at most one bit write per cycle.
module sp_buffer #(
    parameter int OFF_W  = 5,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [$clog2(BYTE_W)-1:0] wr_bit,
    input  logic              wr_val,
    input  logic [OFF_W-1:0]  rd_a_off,
    output logic [BYTE_W-1:0] rd_a_data,
    input  logic [OFF_W-1:0]  rd_b_off,
    output logic [BYTE_W-1:0] rd_b_data
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DEPTH-1:0][BYTE_W-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [BYTE_W-1:0] q;
        // Per-byte storage: update one addressed bit when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_off == OFF_W'(g))) begin
                q[wr_bit] <= wr_val;
            end
        end
        assign cells[g] = q;
    end

    assign rd_a_data = cells[rd_a_off];
    assign rd_b_data = cells[rd_b_off];
endmodule

// File: rtl/sp_auth_chk.sv
`timescale 1ns/1ps
// Echo checker: shifts in N_BYTES*BYTE_W bits LSB first and compares the
// word completed by the current bit against a reference word.
// Assumes clr is held while no echo is being collected.
module sp_auth_chk #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        shift_en,
    input  logic                        bit_in,
    input  logic [BYTE_W*N_BYTES-1:0]   ref_word,
    output logic                        last_bit,
    output logic                        match
);
    localparam int W     = BYTE_W * N_BYTES;
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     sh_q;
    logic [W-1:0]     sh_next;
    logic [CNT_W-1:0] cnt_q;

    assign sh_next = {bit_in, sh_q[W-1:1]};

    // Collect echo bits and count them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= sh_next;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last_bit = shift_en && (cnt_q == CNT_W'(W - 1));
    assign match    = (sh_next == ref_word);
endmodule

// File: rtl/sp_stream_sel.sv
`timescale 1ns/1ps
// Read-back multiplexer: picks the byte for the current position of the
// read stream (two address bytes, status, buffer data, then all ones)
// and the bit within it.
module sp_stream_sel #(
    parameter int BYTE_W = 8
) (
    input  logic [1:0]                hdr_idx,
    input  logic                      past_end,
    input  logic [2*BYTE_W-1:0]       ta_word,
    input  logic [BYTE_W-1:0]         es_byte,
    input  logic [BYTE_W-1:0]         data_byte,
    input  logic [$clog2(BYTE_W)-1:0] bit_idx,
    output logic                      bit_out
);
    logic [BYTE_W-1:0] cur;

    // Select the byte that the stream is currently emitting.
    always_comb begin
        unique case (hdr_idx)
            2'd0:    cur = ta_word[BYTE_W-1:0];
            2'd1:    cur = ta_word[2*BYTE_W-1:BYTE_W];
            2'd2:    cur = es_byte;
            default: cur = past_end ? '1 : data_byte;
        endcase
    end

    assign bit_out = cur[bit_idx];
endmodule

// File: rtl/scratch_copy_ctrl.sv
`timescale 1ns/1ps
// Staged scratch buffer controller. Decodes a framed LSB-first bit
// stream into fill / read-back / authorized-copy commands, keeps the
// target address and status byte, and drives the backing memory write
// port during a copy. Assumes BYTE_W = 8 (status packs offset + 3 flags)
// and OFF_W < ADDR_W <= 2*BYTE_W.
module scratch_copy_ctrl
    import sp_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              dout,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata
);
    localparam int OFF_W      = BYTE_W - 3;
    localparam int BIT_W      = $clog2(BYTE_W);
    localparam int TA_W       = 2 * BYTE_W;
    localparam int AUTH_BYTES = 3;
    localparam logic [OFF_W-1:0] LAST_OFF = '1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    sp_state_e         state_q;
    logic [BIT_W-1:0]  bit_q;
    logic              byte_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [TA_W-1:0]   ta_q;
    logic [OFF_W-1:0]  end_q;
    logic [OFF_W-1:0]  wptr_q;
    logic [OFF_W-1:0]  cptr_q;
    logic              wfull_q;
    logic              of_q;
    logic              pf_q;
    logic              aa_q;
    logic [1:0]        hdr_q;
    logic [OFF_W:0]    rptr_q;

    logic              take;
    logic              byte_last;
    logic [BYTE_W-1:0] cmd_next;
    logic [TA_W-1:0]   ta_next;
    logic              cmd_wr_hit;
    logic [BYTE_W-1:0] es_byte;
    logic              buf_we;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] cp_byte;
    logic              auth_shift;
    logic              auth_clr;
    logic              auth_last;
    logic              auth_match;
    logic              rd_bit;

    assign take       = frame && bit_valid;
    assign byte_last  = (bit_q == LAST_BIT);
    assign cmd_next   = {bit_in, cmd_q[BYTE_W-1:1]};
    assign ta_next    = {bit_in, ta_q[TA_W-1:1]};
    assign cmd_wr_hit = (state_q == ST_CMD) && take && byte_last && (cmd_next == OP_WRITE);
    assign es_byte    = {aa_q, of_q, pf_q, end_q};
    assign buf_we     = (state_q == ST_WDATA) && take && !wfull_q;
    assign auth_shift = (state_q == ST_AUTH) && take;
    assign auth_clr   = (state_q != ST_AUTH);

    // Sequencer: command decode, field counters and copy pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
            bit_q   <= '0;
            byte_q  <= 1'b0;
            cmd_q   <= '0;
            hdr_q   <= '0;
            rptr_q  <= '0;
            cptr_q  <= '0;
        end else if (!frame && (state_q != ST_BUSY)) begin
            state_q <= ST_CMD;
            bit_q   <= '0;
            byte_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CMD: begin
                    if (take) begin
                        cmd_q <= cmd_next;
                        bit_q <= bit_q + BIT_W'(1);
                        if (byte_last) begin
                            case (cmd_next)
                                OP_WRITE: state_q <= ST_WADDR;
                                OP_READ: begin
                                    state_q <= ST_READ;
                                    hdr_q   <= '0;
                                    rptr_q  <= {1'b0, ta_q[OFF_W-1:0]};
                                end
                                OP_COPY: state_q <= ST_AUTH;
                                default: state_q <= ST_SINK;
                            endcase
                        end
                    end
                end
                ST_WADDR: begin
                    if (take) begin
                        bit_q <= bit_q + BIT_W'(1);
                        if (byte_last) begin
                            byte_q <= ~byte_q;
                            if (byte_q) begin
                                state_q <= ST_WDATA;
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (take) begin
                        bit_q <= bit_q + BIT_W'(1);
                    end
                end
                ST_READ: begin
                    if (take) begin
                        bit_q <= bit_q + BIT_W'(1);
                        if (byte_last) begin
                            if (hdr_q != 2'd3) begin
                                hdr_q <= hdr_q + 2'd1;
                            end else if (!rptr_q[OFF_W]) begin
                                rptr_q <= rptr_q + (OFF_W+1)'(1);
                            end
                        end
                    end
                end
                ST_AUTH: begin
                    if (auth_last) begin
                        if (auth_match) begin
                            state_q <= ST_BUSY;
                            cptr_q  <= ta_q[OFF_W-1:0];
                        end else begin
                            state_q <= ST_SINK;
                        end
                    end
                end
                ST_BUSY: begin
                    if (cptr_q == end_q) begin
                        state_q <= ST_DONE;
                    end else begin
                        cptr_q <= cptr_q + OFF_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Address, write pointer and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_q    <= '0;
            end_q   <= '0;
            wptr_q  <= '0;
            wfull_q <= 1'b0;
            of_q    <= 1'b0;
            pf_q    <= 1'b0;
            aa_q    <= 1'b0;
        end else begin
            if (cmd_wr_hit) begin
                aa_q <= 1'b0;
                of_q <= 1'b0;
                pf_q <= 1'b0;
            end
            if ((state_q == ST_WADDR) && take) begin
                ta_q <= ta_next;
                if (byte_last && byte_q) begin
                    wptr_q  <= ta_next[OFF_W-1:0];
                    end_q   <= ta_next[OFF_W-1:0];
                    wfull_q <= 1'b0;
                end
            end
            if (buf_we) begin
                end_q <= wptr_q;
                if (byte_last) begin
                    if (wptr_q == LAST_OFF) begin
                        wfull_q <= 1'b1;
                    end else begin
                        wptr_q <= wptr_q + OFF_W'(1);
                    end
                end
            end
            if ((state_q == ST_WDATA) && take && wfull_q) begin
                of_q <= 1'b1;
            end
            if ((state_q == ST_WDATA) && !frame && (bit_q != '0) && !of_q) begin
                pf_q <= 1'b1;
            end
            if (auth_last && auth_match) begin
                aa_q <= 1'b1;
            end
        end
    end

    sp_buffer #(
        .OFF_W (OFF_W),
        .BYTE_W(BYTE_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_off   (wptr_q),
        .wr_bit   (bit_q),
        .wr_val   (bit_in),
        .rd_a_off (rptr_q[OFF_W-1:0]),
        .rd_a_data(rd_byte),
        .rd_b_off (cptr_q),
        .rd_b_data(cp_byte)
    );

    sp_auth_chk #(
        .BYTE_W (BYTE_W),
        .N_BYTES(AUTH_BYTES)
    ) u_auth (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (auth_clr),
        .shift_en(auth_shift),
        .bit_in  (bit_in),
        .ref_word({es_byte, ta_q}),
        .last_bit(auth_last),
        .match   (auth_match)
    );

    sp_stream_sel #(
        .BYTE_W(BYTE_W)
    ) u_sel (
        .hdr_idx  (hdr_q),
        .past_end (rptr_q[OFF_W]),
        .ta_word  (ta_q),
        .es_byte  (es_byte),
        .data_byte(rd_byte),
        .bit_idx  (bit_q),
        .bit_out  (rd_bit)
    );

    // Serial output: read stream, copy progress, or idle high.
    always_comb begin
        unique case (state_q)
            ST_READ: dout = rd_bit;
            ST_DONE: dout = 1'b0;
            default: dout = 1'b1;
        endcase
    end

    assign mem_we    = (state_q == ST_BUSY);
    assign mem_addr  = {ta_q[ADDR_W-1:OFF_W], cptr_q};
    assign mem_wdata = cp_byte;
endmodule

// File: rtl/sp_checker.sv
`timescale 1ns/1ps
// Property checker for scratch_copy_ctrl, attached by bind below.
module sp_checker
    import sp_pkg::*;
#(
    parameter int OFF_W  = 5,
    parameter int ADDR_W = 9,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame,
    input sp_state_e         state_q,
    input logic              dout,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [OFF_W-1:0]  ta_off,
    input logic [BYTE_W-1:0] es_byte,
    input logic              wr_start
);
    p_write_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr[OFF_W-1:0] >= ta_off) && (mem_addr[OFF_W-1:0] <= es_byte[OFF_W-1:0])));

    p_write_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> es_byte[ES_AA]);

    p_busy_shows_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |-> dout);

    p_busy_ignores_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BUSY) && !frame) |=> ((state_q == ST_BUSY) || (state_q == ST_DONE)));

    p_no_partial_on_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        es_byte[ES_OF] |-> !es_byte[ES_PF]);

    p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (es_byte[ES_OF] && !wr_start) |=> es_byte[ES_OF]);

    p_accept_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (es_byte[ES_AA] && !wr_start) |=> es_byte[ES_AA]);

    p_sink_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SINK) |-> (dout && !mem_we));
endmodule

bind scratch_copy_ctrl sp_checker #(
    .OFF_W (OFF_W),
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame   (frame),
    .state_q (state_q),
    .dout    (dout),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .ta_off  (ta_q[OFF_W-1:0]),
    .es_byte (es_byte),
    .wr_start(cmd_wr_hit)
);

// File: tb/sim_scratch_copy_ctrl.sv
`timescale 1ns/1ps
module sim_scratch_copy_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       dout;
    logic       mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // Behavioural model state
    logic [7:0]  m_buf [32];
    logic [15:0] m_ta;
    logic [4:0]  m_end;
    logic        m_of, m_pf, m_aa;

    scratch_copy_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .frame(frame), .bit_valid(bit_valid),
        .bit_in(bit_in), .dout(dout), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] m_es();
        return {m_aa, m_of, m_pf, m_end};
    endfunction

    function automatic logic [7:0] stream_byte(input int j);
        int o;
        if (j == 0) return m_ta[7:0];
        if (j == 1) return m_ta[15:8];
        if (j == 2) return m_es();
        o = int'(m_ta[4:0]) + j - 3;
        if (o > 31) return 8'hFF;
        return m_buf[o];
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic step(input logic fr, input logic bv, input logic bi, input logic ed,
                        input logic ewe, input logic [8:0] ea, input logic [7:0] ewd);
        @(negedge clk);
        frame = fr;
        bit_valid = bv;
        bit_in = bi;
        #1;
        chk(dout === ed, "dout", 32'(dout), 32'(ed));
        chk(mem_we === ewe, "mem_we", 32'(mem_we), 32'(ewe));
        if (ewe) begin
            chk(mem_addr === ea, "mem_addr", 32'(mem_addr), 32'(ea));
            chk(mem_wdata === ewd, "mem_wdata", 32'(mem_wdata), 32'(ewd));
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int k = 0; k < 8; k++) step(1'b1, 1'b1, b[k], 1'b1, 1'b0, '0, '0);
    endtask

    task automatic idle(input int n, input logic first_d);
        step(1'b0, 1'b0, 1'b0, first_d, 1'b0, '0, '0);
        for (int i = 1; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
    endtask

    task automatic wr(input logic [15:0] ta, input logic [7:0] d[$], input int xbits, input logic [7:0] xval);
        int ptr;
        int k;
        send_byte(8'h0F);
        send_byte(ta[7:0]);
        send_byte(ta[15:8]);
        m_aa = 1'b0; m_of = 1'b0; m_pf = 1'b0;
        m_ta = ta; m_end = ta[4:0];
        ptr = int'(ta[4:0]);
        k = 0;
        for (int i = 0; i < d.size() * 8 + xbits; i++) begin
            logic b;
            b = (i < d.size() * 8) ? d[i / 8][i % 8] : xval[i - d.size() * 8];
            step(1'b1, 1'b1, b, 1'b1, 1'b0, '0, '0);
            if (ptr > 31) begin
                m_of = 1'b1;
            end else begin
                m_buf[ptr][k] = b;
                m_end = 5'(ptr);
            end
            k++;
            if (k == 8) begin
                k = 0;
                ptr++;
            end
        end
        idle(2, 1'b1);
        if (k != 0 && !m_of) m_pf = 1'b1;
    endtask

    task automatic rd(input int n);
        logic [7:0] e;
        send_byte(8'hAA);
        for (int j = 0; j < n; j++) begin
            e = stream_byte(j);
            for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 1'b0, e[k], 1'b0, '0, '0);
        end
        e = stream_byte(n);
        idle(2, e[0]);
    endtask

    task automatic cp(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2, input bit hold);
        logic match;
        match = ({a2, a1, a0} == {m_es(), m_ta});
        send_byte(8'h55);
        send_byte(a0);
        send_byte(a1);
        send_byte(a2);
        if (match) begin
            m_aa = 1'b1;
            for (int o = int'(m_ta[4:0]); o <= int'(m_end); o++)
                step(hold, 1'b0, 1'b0, 1'b1, 1'b1, {m_ta[8:5], o[4:0]}, m_buf[o]);
            if (hold) repeat (3) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
            idle(2, 1'b1);
        end else begin
            repeat (3) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
            idle(2, 1'b1);
        end
    endtask

    initial begin
        logic [7:0] q[$];
        for (int i = 0; i < 32; i++) m_buf[i] = 8'h00;
        m_ta = '0; m_end = '0; m_of = 1'b0; m_pf = 1'b0; m_aa = 1'b0;

        cur_req = "R1";
        repeat (3) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
        rst_n = 1'b1;
        idle(2, 1'b1);
        rd(6);

        cur_req = "R2";
        q = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr(16'h0123, q, 0, 8'h00);
        cur_req = "R5";
        rd(10);

        cur_req = "R7";
        cp(8'h23, 8'h01, 8'h06, 1'b1);
        cur_req = "R11";
        rd(3);
        rd(3);

        cur_req = "R4";
        q = '{8'hAB, 8'hCD};
        wr(16'h01FC, q, 3, 8'h05);
        cur_req = "R6";
        rd(8);

        cur_req = "R8";
        cp(8'hFC, 8'h01, 8'h1E, 1'b0);
        rd(3);

        cur_req = "R10";
        cp(8'hFC, 8'h01, 8'h3E, 1'b0);
        cur_req = "R9";
        rd(3);

        cur_req = "R3";
        q = '{8'h5A, 8'hA5, 8'h77};
        wr(16'h003E, q, 2, 8'h03);
        rd(6);

        cur_req = "R12";
        send_byte(8'h33);
        send_byte(8'hFF);
        send_byte(8'h0F);
        idle(2, 1'b1);
        rd(6);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule